// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block sits behind the serial front-end of a small byte-addressed non-volatile memory. It owns the eight-bit status byte that the host reads back, the write-enable latch that arms a single modification, the two-bit protection level, and the flag that shows a self-timed write cycle is running. The front-end hands it one-cycle pulses for the decoded write-enable, write-disable and status-write instructions, along with the data byte of a status write. A separate write-cycle timer hands it start and finish pulses.

In return the block gives the status byte for readback and a permit for status-register updates. It also gives a permit for the array byte address currently presented. That permit combines four things: the hardware protect pin (active low), the write-enable latch, the upper-region protection level, and whether a cycle is in flight. The protection level is kept in ordinary resettable flops. A status write that is accepted is held aside and only takes effect when its write cycle finishes.

Top module: `prot_stat_unit`

## Requirements
- R1: When idle, the status byte carries the busy flag in bit 0, the write-enable latch in bit 1, and the protection level in bits 3:2 (bit 2 is the low bit). Bits 7:4 always read 0.
- R2: From the cycle after a start pulse until a finish pulse is taken, the status byte reads 0xFF. The block is ready again in the cycle after the finish pulse.
- R3: A write-enable pulse sets the latch only when the block is idle, the protect pin is high, and no write-disable pulse arrives in the same cycle.
- R4: The latch is cleared by a write-disable pulse, by a finished write cycle, and in every cycle that follows one in which the protect pin is low.
- R5: The protection level maps onto the two top address bits. Level 00 guards nothing. Level 01 guards the top quarter (top bits 11). Level 10 guards the upper half (top bit 1). Level 11 guards every address.
- R6: The array permit is high only when all of these hold: the latch is set, the pin is high, the block is idle, and the presented address lies outside the guarded region. The permit follows the address combinationally.
- R7: The status permit is high only when the latch is set, the pin is high and the block is idle. A status-write pulse without that permit changes nothing.
- R8: An accepted status write takes the new level from data bits 3:2 and discards all other data bits. The level changes only in the cycle after the finish pulse of the next write cycle.
- R9: While busy, write-enable, write-disable and status-write pulses have no effect.
- R10: After reset, the latch, the level and the busy flag are all 0, so the status byte reads 0x00 and both permits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Hardware protect pin, low protects |
| op_wren_i | input | 1 | Decoded write-enable instruction pulse |
| op_wrdi_i | input | 1 | Decoded write-disable instruction pulse |
| op_wrsr_i | input | 1 | Completed status-write instruction pulse |
| sr_data_i | input | 8 | Data byte of the status write |
| cyc_start_i | input | 1 | Write cycle start pulse from the timer |
| cyc_done_i | input | 1 | Write cycle finish pulse from the timer |
| addr_i | input | ADDR_W | Array byte address under test |
| status_o | output | 8 | Status byte for readback |
| sr_wr_ok_o | output | 1 | Status-register update permitted |
| arr_wr_ok_o | output | 1 | Array write to addr_i permitted |

## Verification
The bench builds the block with its defaults: a nine-bit address (512 bytes) and deferred level update. With these defaults the quarter boundary falls at 0x180 and the half boundary at 0x100. Directed steps walk all four levels across those edges. They also cover a status write that is refused and pulses issued while busy. A long random phase then mixes protect-pin drops, simultaneous enable and disable pulses, and stray finish pulses, against the behavioural model.

// File: rtl/prot_stat_pkg.sv
package prot_stat_pkg;

   localparam int STAT_W   = 8;
   localparam int STB_RDY  = 0;
   localparam int STB_WEN  = 1;
   localparam int STB_LVL  = 2;
   localparam int LVL_W    = 2;

   typedef enum logic [LVL_W-1:0] {
      PL_NONE    = 2'b00,
      PL_QUARTER = 2'b01,
      PL_HALF    = 2'b10,
      PL_ALL     = 2'b11
   } prot_lvl_e;

   function automatic logic lvl_guards(input prot_lvl_e lvl, input logic [1:0] top);
      case (lvl)
         PL_NONE:    return 1'b0;
         PL_QUARTER: return top == 2'b11;
         PL_HALF:    return top[1];
         default:    return 1'b1;
      endcase
   endfunction

endpackage

// File: rtl/ps_cycle_track.sv
module ps_cycle_track (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic done_i,
   output logic busy_o
);

   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                busy_q <= 1'b0;
      else if (!busy_q && start_i) busy_q <= 1'b1;
      else if (busy_q && done_i)   busy_q <= 1'b0;
   end

   assign busy_o = busy_q;

   assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && done_i) |=> !busy_q);

   assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && start_i) |=> busy_q);

endmodule

// File: rtl/ps_wen_latch.sv
module ps_wen_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic wp_n_i,
   input  logic busy_i,
   input  logic done_i,
   input  logic wren_i,
   input  logic wrdi_i,
   output logic wen_o
);

   logic wen_q;
   logic wen_d;

   always_comb begin
      wen_d = wen_q;
      if (!wp_n_i)                wen_d = 1'b0;
      else if (busy_i) begin
         if (done_i)              wen_d = 1'b0;
      end
      else if (wrdi_i)            wen_d = 1'b0;
      else if (wren_i)            wen_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wen_q <= 1'b0;
      else        wen_q <= wen_d;
   end

   assign wen_o = wen_q;

   assert_wen_pin_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n_i |=> !wen_q);

   assert_wen_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && !wen_q) |=> !wen_q);

   assert_wen_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && done_i) |=> !wen_q);

endmodule

// File: rtl/ps_level_store.sv
module ps_level_store
   import prot_stat_pkg::*;
#(
   parameter bit DEFER_LVL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic              accept_i,
   input  logic [STAT_W-1:0] data_i,
   output prot_lvl_e         lvl_o
);

   prot_lvl_e lvl_q;
   prot_lvl_e new_lvl;
   logic      unused_data_bits;

   assign new_lvl          = prot_lvl_e'(data_i[STB_LVL +: LVL_W]);
   assign unused_data_bits = ^{data_i[STAT_W-1:STB_LVL+LVL_W], data_i[STB_LVL-1:0]};

   generate
      if (DEFER_LVL) begin : g_defer
         logic      pend_q;
         prot_lvl_e pend_lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_q     <= 1'b0;
               pend_lvl_q <= PL_NONE;
               lvl_q      <= PL_NONE;
            end
            else if (busy_i) begin
               if (done_i) begin
                  if (pend_q) lvl_q <= pend_lvl_q;
                  pend_q <= 1'b0;
               end
            end
            else if (accept_i) begin
               pend_q     <= 1'b1;
               pend_lvl_q <= new_lvl;
            end
         end

         assert_lvl_moves_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(busy_i && done_i) |=> $stable(lvl_q));
      end
      else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   lvl_q <= PL_NONE;
            else if (!busy_i && accept_i) lvl_q <= new_lvl;
         end
      end
   endgenerate

   assign lvl_o = lvl_q;

endmodule

// File: rtl/ps_region_decode.sv
module ps_region_decode
   import prot_stat_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  prot_lvl_e          lvl_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               open_i,
   output logic               ok_o
);

   localparam int TOP_LSB = ADDR_W - 2;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("ps_region_decode: ADDR_W must be at least 2");
      end
   endgenerate

   logic [1:0] top;
   logic       guarded;
   logic       unused_low_addr;

   assign top             = addr_i[ADDR_W-1:TOP_LSB];
   assign unused_low_addr = ^addr_i;
   assign guarded         = lvl_guards(lvl_i, top);
   assign ok_o            = open_i && !guarded;

endmodule

// File: rtl/prot_stat_unit.sv
module prot_stat_unit
   import prot_stat_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter bit DEFER_LVL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n_i,
   input  logic              op_wren_i,
   input  logic              op_wrdi_i,
   input  logic              op_wrsr_i,
   input  logic [7:0]        sr_data_i,
   input  logic              cyc_start_i,
   input  logic              cyc_done_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [7:0]        status_o,
   output logic              sr_wr_ok_o,
   output logic              arr_wr_ok_o
);

   generate
      if (STAT_W != 8) begin : g_bad_stat
         $error("prot_stat_unit: status byte must be 8 bits");
      end
   endgenerate

   logic      busy;
   logic      wen;
   logic      open_wr;
   prot_lvl_e lvl;

   ps_cycle_track u_cyc (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (cyc_start_i),
      .done_i  (cyc_done_i),
      .busy_o  (busy)
   );

   ps_wen_latch u_wen (
      .clk    (clk),
      .rst_n  (rst_n),
      .wp_n_i (wp_n_i),
      .busy_i (busy),
      .done_i (cyc_done_i),
      .wren_i (op_wren_i),
      .wrdi_i (op_wrdi_i),
      .wen_o  (wen)
   );

   assign open_wr = wen && wp_n_i && !busy;

   ps_level_store #(.DEFER_LVL(DEFER_LVL)) u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy_i   (busy),
      .done_i   (cyc_done_i),
      .accept_i (op_wrsr_i && open_wr),
      .data_i   (sr_data_i),
      .lvl_o    (lvl)
   );

   ps_region_decode #(.ADDR_W(ADDR_W)) u_dec (
      .lvl_i  (lvl),
      .addr_i (addr_i),
      .open_i (open_wr),
      .ok_o   (arr_wr_ok_o)
   );

   always_comb begin
      status_o = '0;
      if (busy) begin
         status_o = '1;
      end
      else begin
         status_o[STB_RDY]             = 1'b0;
         status_o[STB_WEN]             = wen;
         status_o[STB_LVL +: LVL_W]    = lvl;
      end
   end

   assign sr_wr_ok_o = open_wr;

   assert_arr_needs_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_ok_o |-> (wp_n_i && status_o[STB_WEN] && !status_o[STB_RDY]));

   assert_full_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == PL_ALL) |-> !arr_wr_ok_o);

   assert_busy_reads_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (status_o == 8'hFF));

   assert_sr_permit_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n_i |-> !sr_wr_ok_o);

endmodule

// File: tb/sim_prot_stat_unit.sv
module sim_prot_stat_unit;

   localparam int AW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wp_n = 1'b1;
   logic          wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
   logic [7:0]    sdat = 8'h00;
   logic          cst = 1'b0, cdn = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    status;
   logic          sr_ok, arr_ok;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   int m_busy = 0, m_wen = 0, m_lvl = 0, m_pend = 0, m_plvl = 0;

   always #4 clk = ~clk;

   prot_stat_unit #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n),
      .op_wren_i(wren), .op_wrdi_i(wrdi), .op_wrsr_i(wrsr), .sr_data_i(sdat),
      .cyc_start_i(cst), .cyc_done_i(cdn), .addr_i(addr),
      .status_o(status), .sr_wr_ok_o(sr_ok), .arr_wr_ok_o(arr_ok)
   );

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cycles, got, exp);
      end
   endtask

   function automatic int m_guard(input int a, input int lvl);
      int top = (a >> (AW - 2)) & 3;
      if (lvl == 0) return 0;
      if (lvl == 1) return (top == 3) ? 1 : 0;
      if (lvl == 2) return (top >= 2) ? 1 : 0;
      return 1;
   endfunction

   function automatic int m_open();
      return (m_wen == 1 && wp_n == 1'b1 && m_busy == 0) ? 1 : 0;
   endfunction

   task automatic model_step();
      int open_now;
      int nbusy, nwen, nlvl, npend, nplvl;
      if (!rst_n) begin
         m_busy = 0; m_wen = 0; m_lvl = 0; m_pend = 0; m_plvl = 0;
         return;
      end
      open_now = m_open();
      nbusy = m_busy; nwen = m_wen; nlvl = m_lvl; npend = m_pend; nplvl = m_plvl;
      if (m_busy == 0 && cst) nbusy = 1;
      else if (m_busy == 1 && cdn) nbusy = 0;
      if (!wp_n) nwen = 0;
      else if (m_busy == 1) begin
         if (cdn) nwen = 0;
      end
      else if (wrdi) nwen = 0;
      else if (wren) nwen = 1;
      if (m_busy == 1) begin
         if (cdn) begin
            if (m_pend == 1) nlvl = m_plvl;
            npend = 0;
         end
      end
      else if (wrsr && open_now == 1) begin
         npend = 1; nplvl = (sdat >> 2) & 3;
      end
      m_busy = nbusy; m_wen = nwen; m_lvl = nlvl; m_pend = npend; m_plvl = nplvl;
   endtask

   task automatic compare_all();
      int exp_stat;
      exp_stat = (m_busy == 1) ? 8'hFF : ((m_lvl << 2) | (m_wen << 1));
      chk("R1 R2 status byte", int'(status), exp_stat);
      chk("R7 status permit", int'(sr_ok), m_open());
      chk("R5 R6 array permit", int'(arr_ok),
          (m_open() == 1 && m_guard(int'(addr), m_lvl) == 0) ? 1 : 0);
   endtask

   task automatic cyc(input logic i_wren, input logic i_wrdi, input logic i_wrsr,
                      input logic [7:0] i_dat, input logic i_st, input logic i_dn,
                      input logic i_wp, input logic [AW-1:0] i_a);
      @(negedge clk);
      cycles++;
      model_step();
      wren = i_wren; wrdi = i_wrdi; wrsr = i_wrsr; sdat = i_dat;
      cst = i_st; cdn = i_dn; wp_n = i_wp; addr = i_a;
      #1;
      compare_all();
   endtask

   task automatic idle(input logic [AW-1:0] a);
      cyc(0, 0, 0, 8'h00, 0, 0, 1, a);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d: got hang expected completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R10 reset status", int'(status), 8'h00);
      chk("R10 reset status permit", int'(sr_ok), 0);
      chk("R10 reset array permit", int'(arr_ok), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(9'h000);

      // R3 set latch
      cyc(1, 0, 0, 8'h00, 0, 0, 1, 9'h000);
      idle(9'h000);
      chk("R3 latch set", int'(status), 8'h02);
      chk("R6 open address", int'(arr_ok), 1);
      // R4 write-disable clears
      cyc(0, 1, 0, 8'h00, 0, 0, 1, 9'h000);
      idle(9'h000);
      chk("R4 disable clears", int'(status), 8'h00);
      // R3 disable wins in same cycle
      cyc(1, 1, 0, 8'h00, 0, 0, 1, 9'h000);
      idle(9'h000);
      chk("R3 disable wins", int'(status), 8'h00);

      // R8 deferred level, data 0xF5 -> level 01
      cyc(1, 0, 0, 8'h00, 0, 0, 1, 9'h000);
      cyc(0, 0, 1, 8'hF5, 0, 0, 1, 9'h000);
      idle(9'h000);
      chk("R8 level not yet applied", int'(status), 8'h02);
      cyc(0, 0, 0, 8'h00, 1, 0, 1, 9'h000);
      idle(9'h000);
      chk("R2 busy reads ones", int'(status), 8'hFF);
      chk("R9 no permit while busy", int'(sr_ok), 0);
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000);
      idle(9'h000);
      chk("R8 R4 level after finish", int'(status), 8'h04);

      // R9 enable while busy ignored
      cyc(0, 0, 0, 8'h00, 1, 0, 1, 9'h000);
      cyc(1, 0, 0, 8'h00, 0, 0, 1, 9'h000);
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000);
      idle(9'h000);
      chk("R9 enable while busy ignored", int'(status), 8'h04);

      // R5 quarter boundary
      cyc(1, 0, 0, 8'h00, 0, 0, 1, 9'h17F);
      idle(9'h17F);
      chk("R5 quarter below edge", int'(arr_ok), 1);
      idle(9'h180);
      chk("R5 quarter at edge", int'(arr_ok), 0);
      // level 10
      cyc(0, 0, 1, 8'h08, 0, 0, 1, 9'h000);
      cyc(0, 0, 0, 8'h00, 1, 0, 1, 9'h000);
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000);
      cyc(1, 0, 0, 8'h00, 0, 0, 1, 9'h0FF);
      idle(9'h0FF);
      chk("R5 half below edge", int'(arr_ok), 1);
      idle(9'h100);
      chk("R5 half at edge", int'(arr_ok), 0);
      chk("R1 level 10 layout", int'(status), 8'h0A);
      // level 11
      cyc(0, 0, 1, 8'h0C, 0, 0, 1, 9'h000);
      cyc(0, 0, 0, 8'h00, 1, 0, 1, 9'h000);
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000);
      cyc(1, 0, 0, 8'h00, 0, 0, 1, 9'h000);
      idle(9'h000);
      chk("R5 full guard", int'(arr_ok), 0);
      chk("R7 status still writable", int'(sr_ok), 1);

      // R7 refused status write: drop latch then try
      cyc(0, 1, 0, 8'h00, 0, 0, 1, 9'h000);
      cyc(0, 0, 1, 8'h00, 0, 0, 1, 9'h000);
      cyc(0, 0, 0, 8'h00, 1, 0, 1, 9'h000);
      cyc(0, 0, 0, 8'h00, 0, 1, 1, 9'h000);
      idle(9'h000);
      chk("R7 refused write keeps level", int'(status), 8'h0C);

      // R4 pin low clears, R3 enable under low pin ignored
      cyc(1, 0, 0, 8'h00, 0, 0, 1, 9'h000);
      cyc(0, 0, 0, 8'h00, 0, 0, 0, 9'h000);
      cyc(0, 0, 0, 8'h00, 0, 0, 0, 9'h000);
      chk("R4 pin low clears latch", int'(status), 8'h0C);
      cyc(1, 0, 0, 8'h00, 0, 0, 0, 9'h000);
      cyc(0, 0, 0, 8'h00, 0, 0, 0, 9'h000);
      chk("R3 enable under low pin", int'(status), 8'h0C);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         cyc(($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
             8'($urandom), ($urandom % 6) == 0, ($urandom % 5) == 0,
             ($urandom % 10) != 0, AW'($urandom));
         if (r == 8'h00) idle(AW'(r));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule